// File: doc/BRIEF.md
# Static RAM Pattern Test Sequencer

This block exercises an external asynchronous static RAM of 4K words by 4 bits with a fixed functional test, then reports whether the part passed. The host pulses `start`. The sequencer then drives the RAM's address, active-low select, active-low write strobe and data bus through a scripted list of 70 accesses, and compares every read against the value it expects. When the list is exhausted it pulses `done`. `pass` then shows the verdict, and the `fail_*` outputs hold the first mismatch that was found.

Each access spans three equal periods of `CYCLE_CLKS` clocks. In the first period the address is set up with both enables idle. In the second the access itself takes place. In the third both enables are released. Read data is captured `STROBE_CLKS` clocks into the access period, so a slow part has a fixed settling window before the sample.

The script has three parts. First, each data bit is checked on its own at address zero. Next come two write-everything-then-read-everything passes over a thermometer-coded address set, each pass with its own data table. Last comes a check that a deselected read returns the pulled-up value on the bus.

Top module: `sram_pattern_tester`

## Requirements
- R1: While `rst` is high and on the clock after it, `busy`, `done` and `pass` are 0, `mem_cs_n` and `mem_we_n` are 1 and `mem_dq_oe` is 0.
- R2: Each access lasts exactly 3×`CYCLE_CLKS` clocks, split into setup, access and release periods. In setup and release, `mem_cs_n`=`mem_we_n`=1. The address is constant for the whole access, and address, enables and bus control change only on period boundaries.
- R3: In both pattern passes, entry i (i = 0..12) uses an address whose i least significant bits are 1 and whose other bits are 0.
- R4: In the access period of a write, `mem_cs_n`=0, `mem_we_n`=0, `mem_dq_oe`=1. In the access period of a read, `mem_cs_n`=0, `mem_we_n`=1, `mem_dq_oe`=0. `mem_dq_oe` is 0 at all other times.
- R5: Step order: steps 0–15 are the bit tests. Steps 16–28 write table A (hex 0,1,3,7,F,E,C,8,A,2,6,2,6) to entries 0..12, and steps 29–41 read those entries back. Steps 42–54 write table B (hex F,E,C,8,0,1,3,7,5,D,9,D,9), and steps 55–67 read them back. Step 68 writes 0000 to address 0. Step 69 is the deselected read.
- R6: Read data is sampled on the clock edge that ends the `STROBE_CLKS`-th clock of the access period. Bus values in the other clocks of that period do not affect the result.
- R7: For bit b, steps 4b..4b+3 at address 0 run in this order: write 0000, read, write a word with only bit b set, read. Each of these reads compares bit b only.
- R8: In step 69, `mem_cs_n` and `mem_we_n` stay 1 for all three periods, and the value sampled must be 1111.
- R9: The first mismatch clears `pass` and records `fail_step`, `fail_addr`, `fail_exp` (the expected word) and `fail_got` (the raw sampled word). Later mismatches leave the record unchanged. The run still finishes all 70 steps. `done` is high for exactly one clock, 210×`CYCLE_CLKS` clocks after the edge that accepted `start`. `pass` is 1 at `done` only if no read mismatched.
- R10: `start` asserted while `busy` is 1 has no effect on the sequence or its duration.
- R11: A synchronous reset in the middle of a run returns the block to the idle state of R1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse at end of run |
| pass | output | 1 | No mismatch seen in the current or last run |
| fail_step | output | STEP_W | Step index of first mismatch |
| fail_addr | output | AW | Address of first mismatch |
| fail_exp | output | 4 | Expected word at first mismatch |
| fail_got | output | 4 | Sampled word at first mismatch |
| mem_addr | output | AW | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 4 | Data driven to the RAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 4 | Data received from the RAM bus |

## Verification
The sequencer is run against a behavioural RAM that returns valid data only in the single clock before the strobe edge and inverted data otherwise, so any shift of the sample point shows up as a failure. A fault-free part must pass. A bit flipped at address zero must be caught first by the matching single-bit test and not by an earlier test of another bit. A part that ignores chip select must fail only at the deselected read. An address line stuck low must fail at the first read of an aliased entry. Random faults from these classes are compared against a bench prediction of the first failing step, address and data, and every clock of every run is checked against the expected address and control waveform.

// File: rtl/sramt_pkg.sv
package sramt_pkg;

  localparam int DW      = 4;
  localparam int TBL_LEN = 13;

  typedef enum logic [1:0] {
    ACC_WR  = 2'd0,
    ACC_RD  = 2'd1,
    ACC_DSL = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_DATA  = 2'd1,
    PH_HOLD  = 2'd2
  } ph_e;

  // data words for the first write/read pass
  function automatic logic [DW-1:0] ramp_word(input int i);
    case (i % TBL_LEN)
      0:  return 4'h0;
      1:  return 4'h1;
      2:  return 4'h3;
      3:  return 4'h7;
      4:  return 4'hF;
      5:  return 4'hE;
      6:  return 4'hC;
      7:  return 4'h8;
      8:  return 4'hA;
      9:  return 4'h2;
      10: return 4'h6;
      11: return 4'h2;
      default: return 4'h6;
    endcase
  endfunction

  // data words for the second write/read pass
  function automatic logic [DW-1:0] walk_word(input int i);
    case (i % TBL_LEN)
      0:  return 4'hF;
      1:  return 4'hE;
      2:  return 4'hC;
      3:  return 4'h8;
      4:  return 4'h0;
      5:  return 4'h1;
      6:  return 4'h3;
      7:  return 4'h7;
      8:  return 4'h5;
      9:  return 4'hD;
      10: return 4'h9;
      11: return 4'hD;
      default: return 4'h9;
    endcase
  endfunction

endpackage

// File: rtl/sramt_step_decode.sv
module sramt_step_decode
  import sramt_pkg::*;
#(
  parameter int AW = 12,
  parameter int SW = 8
) (
  input  logic [SW-1:0] step,
  output acc_e          kind,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] expv,
  output logic [DW-1:0] mask
);

  localparam int NADDR      = AW + 1;
  localparam int BIT_STEPS  = 4 * DW;
  localparam int PASS_STEPS = 2 * NADDR;
  localparam int MAIN_END   = BIT_STEPS + 2 * PASS_STEPS;

  always_comb begin
    int          s;
    int          rel;
    int          idx;
    logic        rd;
    logic [AW:0] onehot;
    logic [DW-1:0] bitm;
    s      = int'(step);
    rel    = 0;
    idx    = 0;
    rd     = 1'b0;
    onehot = '0;
    bitm   = '0;
    kind   = ACC_WR;
    addr   = '0;
    wdata  = '0;
    expv   = '0;
    mask   = '1;
    if (s < BIT_STEPS) begin
      // single-bit tests at address zero
      bitm  = DW'(1) << (s / 4);
      mask  = bitm;
      wdata = ((s % 4) >= 2) ? bitm : '0;
      expv  = wdata;
      kind  = ((s % 2) == 1) ? ACC_RD : ACC_WR;
    end else if (s < MAIN_END) begin
      rel    = (s - BIT_STEPS) % PASS_STEPS;
      rd     = (rel >= NADDR);
      idx    = rd ? rel - NADDR : rel;
      onehot = (AW+1)'(1) << idx;
      addr   = AW'(onehot - 1'b1);
      wdata  = ((s - BIT_STEPS) < PASS_STEPS) ? ramp_word(idx) : walk_word(idx);
      expv   = wdata;
      kind   = rd ? ACC_RD : ACC_WR;
    end else if (s == MAIN_END) begin
      kind  = ACC_WR;
    end else begin
      kind  = ACC_DSL;
      expv  = '1;
    end
  end

endmodule

// File: rtl/sramt_timer.sv
module sramt_timer
  import sramt_pkg::*;
#(
  parameter int CYCLE_CLKS = 200,
  parameter int NSTEP      = 70,
  parameter int SW         = 8,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          busy_q,
  output logic [SW-1:0] step_q,
  output ph_e           phase_q,
  output logic [CW-1:0] cnt_q,
  output logic          last_clk,
  output logic          fin_q,
  output logic          busy_d,
  output logic [SW-1:0] step_d,
  output ph_e           phase_d
);

  logic [CW-1:0] cnt_d;
  logic          fin_d;

  assign last_clk = busy_q && (cnt_q == CW'(CYCLE_CLKS - 1));

  always_comb begin
    busy_d  = busy_q;
    step_d  = step_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    fin_d   = 1'b0;
    if (!busy_q) begin
      if (go) begin
        busy_d  = 1'b1;
        step_d  = '0;
        phase_d = PH_SETUP;
        cnt_d   = '0;
      end
    end else if (last_clk) begin
      cnt_d = '0;
      if (phase_q == PH_HOLD) begin
        phase_d = PH_SETUP;
        if (step_q == SW'(NSTEP - 1)) begin
          busy_d = 1'b0;
          fin_d  = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else begin
        phase_d = (phase_q == PH_SETUP) ? PH_DATA : PH_HOLD;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      phase_q <= PH_SETUP;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      step_q  <= step_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      fin_q   <= fin_d;
    end
  end

endmodule

// File: rtl/sramt_compare.sv
module sramt_compare
  import sramt_pkg::*;
#(
  parameter int AW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          strobe,
  input  acc_e          kind,
  input  logic [SW-1:0] step,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] expv,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] dq_in,
  output logic          pass_q,
  output logic [SW-1:0] fstep_q,
  output logic [AW-1:0] faddr_q,
  output logic [DW-1:0] fexp_q,
  output logic [DW-1:0] fgot_q
);

  logic seen_q;
  logic mism;

  assign mism = (kind != ACC_WR) && (((dq_in ^ expv) & mask) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q  <= 1'b0;
      seen_q  <= 1'b0;
      fstep_q <= '0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fgot_q  <= '0;
    end else if (clear) begin
      pass_q  <= 1'b1;
      seen_q  <= 1'b0;
      fstep_q <= '0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fgot_q  <= '0;
    end else if (strobe && mism && !seen_q) begin
      pass_q  <= 1'b0;
      seen_q  <= 1'b1;
      fstep_q <= step;
      faddr_q <= addr;
      fexp_q  <= expv;
      fgot_q  <= dq_in;
    end
  end

endmodule

// File: rtl/sram_pattern_tester.sv
module sram_pattern_tester
  import sramt_pkg::*;
#(
  parameter int AW          = 12,
  parameter int CYCLE_CLKS  = 200,
  parameter int STROBE_CLKS = 180,
  parameter int STEP_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [STEP_W-1:0] fail_step,
  output logic [AW-1:0]     fail_addr,
  output logic [3:0]        fail_exp,
  output logic [3:0]        fail_got,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic [3:0]        mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [3:0]        mem_dq_in
);

  localparam int NADDR = AW + 1;
  localparam int NSTEP = 4 * DW + 4 * NADDR + 2;
  localparam int CW    = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 1;

  logic              busy_q, busy_d, last_clk, fin_q;
  logic [STEP_W-1:0] step_q, step_d;
  ph_e               phase_q, phase_d;
  logic [CW-1:0]     cnt_q;

  acc_e              d_kind;
  logic [AW-1:0]     d_addr;
  logic [DW-1:0]     d_wdata, d_expv, d_mask;

  acc_e              kind_q;
  logic [DW-1:0]     expv_q, mask_q;
  logic [AW-1:0]     addr_q;
  logic              cs_n_q, we_n_q, oe_q;
  logic [DW-1:0]     dout_q;
  logic              strobe;

  sramt_timer #(
    .CYCLE_CLKS(CYCLE_CLKS), .NSTEP(NSTEP), .SW(STEP_W), .CW(CW)
  ) u_timer (
    .clk(clk), .rst(rst), .go(start),
    .busy_q(busy_q), .step_q(step_q), .phase_q(phase_q), .cnt_q(cnt_q),
    .last_clk(last_clk), .fin_q(fin_q),
    .busy_d(busy_d), .step_d(step_d), .phase_d(phase_d)
  );

  // decode the step that the outputs will present next
  sramt_step_decode #(.AW(AW), .SW(STEP_W)) u_decode (
    .step(step_d), .kind(d_kind), .addr(d_addr),
    .wdata(d_wdata), .expv(d_expv), .mask(d_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_q   <= 1'b0;
      dout_q <= '0;
      kind_q <= ACC_WR;
      expv_q <= '0;
      mask_q <= '0;
    end else if (busy_d) begin
      addr_q <= d_addr;
      kind_q <= d_kind;
      expv_q <= d_expv;
      mask_q <= d_mask;
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_q   <= 1'b0;
      dout_q <= '0;
      if (phase_d == PH_DATA) begin
        case (d_kind)
          ACC_WR: begin
            cs_n_q <= 1'b0;
            we_n_q <= 1'b0;
            oe_q   <= 1'b1;
            dout_q <= d_wdata;
          end
          ACC_RD: cs_n_q <= 1'b0;
          default: ;
        endcase
      end
    end else begin
      addr_q <= '0;
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_q   <= 1'b0;
      dout_q <= '0;
    end
  end

  assign strobe = busy_q && (phase_q == PH_DATA) && (cnt_q == CW'(STROBE_CLKS - 1));

  sramt_compare #(.AW(AW), .SW(STEP_W)) u_compare (
    .clk(clk), .rst(rst), .clear(start && !busy_q), .strobe(strobe),
    .kind(kind_q), .step(step_q), .addr(addr_q), .expv(expv_q), .mask(mask_q),
    .dq_in(mem_dq_in),
    .pass_q(pass), .fstep_q(fail_step), .faddr_q(fail_addr),
    .fexp_q(fail_exp), .fgot_q(fail_got)
  );

  assign busy       = busy_q;
  assign done       = fin_q;
  assign mem_addr   = addr_q;
  assign mem_cs_n   = cs_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_dq_oe  = oe_q;
  assign mem_dq_out = dout_q;

endmodule

// File: rtl/sramt_chk.sv
module sramt_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          last_clk,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);

  // R1
  idle_after_rst_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !pass && mem_cs_n && mem_we_n && !mem_dq_oe));

  // R2
  hold_in_period_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_clk) |=> $stable({mem_addr, mem_cs_n, mem_we_n, mem_dq_oe}));

  // R2
  addr_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cs_n) |-> $stable(mem_addr));

  // R4
  bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_cs_n && !mem_we_n && busy));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done) && !$rose(pass));

endmodule

bind sram_pattern_tester sramt_chk #(.AW(AW)) u_sramt_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
  .last_clk(last_clk), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/test_sram_pattern_tester.sv
`timescale 1ns/1ps
module test_sram_pattern_tester;

  localparam int AW     = 12;
  localparam int CYC    = 10;
  localparam int STB    = 8;
  localparam int NST    = 70;
  localparam int RUNLEN = 3 * NST * CYC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, pass;
  logic [7:0]  fail_step;
  logic [11:0] fail_addr;
  logic [3:0]  fail_exp, fail_got;
  logic [11:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_dq_oe;
  logic [3:0]  mem_dq_out, mem_dq_in;

  always #2.5 clk = ~clk;

  sram_pattern_tester #(
    .AW(AW), .CYCLE_CLKS(CYC), .STROBE_CLKS(STB), .STEP_W(8)
  ) i_sram_pattern_tester (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
    .fail_step(fail_step), .fail_addr(fail_addr), .fail_exp(fail_exp),
    .fail_got(fail_got), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- bench step script (kind 0 write, 1 read, 2 deselected read)
  int          st_kind [NST];
  logic [11:0] st_addr [NST];
  logic [3:0]  st_data [NST];
  logic [3:0]  st_mask [NST];
  int          nfill;

  localparam logic [3:0] TA [13] = '{4'h0,4'h1,4'h3,4'h7,4'hF,4'hE,4'hC,4'h8,4'hA,4'h2,4'h6,4'h2,4'h6};
  localparam logic [3:0] TB [13] = '{4'hF,4'hE,4'hC,4'h8,4'h0,4'h1,4'h3,4'h7,4'h5,4'hD,4'h9,4'hD,4'h9};

  task automatic push(input int k, input logic [11:0] a, input logic [3:0] d, input logic [3:0] m);
    st_kind[nfill] = k;
    st_addr[nfill] = a;
    st_data[nfill] = d;
    st_mask[nfill] = m;
    nfill++;
  endtask

  task automatic build_script();
    nfill = 0;
    for (int b = 0; b < 4; b++) begin            // R7
      logic [3:0] one;
      one = 4'b0001 << b;
      push(0, 12'h000, 4'h0, one);
      push(1, 12'h000, 4'h0, one);
      push(0, 12'h000, one,  one);
      push(1, 12'h000, one,  one);
    end
    for (int p = 0; p < 2; p++)                   // R5
      for (int rw = 0; rw < 2; rw++)
        for (int i = 0; i < 13; i++)
          push(rw, 12'hFFF >> (12 - i), (p == 0) ? TA[i] : TB[i], 4'hF);  // R3
    push(0, 12'h000, 4'h0, 4'hF);
    push(2, 12'h000, 4'hF, 4'hF);                 // R8
  endtask

  // ---------------- behavioural RAM with fault injection
  // fk: 0 none, 1 flip fm at address fa on read, 2 ignores chip select, 3 address line fl stuck low
  logic [3:0]  ram [4096];
  int          fk = 0;
  logic [11:0] fa = '0;
  logic [3:0]  fm = '0;
  int          fl = 0;
  int          lat = 0;
  logic [11:0] a_eff;
  logic [3:0]  v_rd;

  always_comb a_eff = (fk == 3) ? (mem_addr & ~(12'd1 << fl)) : mem_addr;

  always @(posedge clk) begin
    lat <= mem_cs_n ? 0 : lat + 1;
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) ram[a_eff] <= mem_dq_out;
  end

  // R6: selected read data is valid only in the clock that ends at the strobe edge
  always_comb begin
    v_rd = ram[a_eff];
    if (fk == 1 && a_eff == fa) v_rd = v_rd ^ fm;
    if (!mem_cs_n && mem_we_n)
      mem_dq_in = (lat == STB - 1) ? v_rd : ~v_rd;
    else if (fk == 2 && mem_we_n)
      mem_dq_in = v_rd;
    else
      mem_dq_in = 4'hF;
  end

  task automatic clear_ram();
    for (int i = 0; i < 4096; i++) ram[i] = 4'h0;
  endtask

  // ---------------- prediction of the first failing read
  function automatic void predict(input int k, input logic [11:0] a, input logic [3:0] m,
                                  input int l, output int ps, output logic [11:0] pa,
                                  output logic [3:0] pe, output logic [3:0] pg);
    logic [3:0] pm [int];
    ps = -1; pa = '0; pe = '0; pg = '0;
    for (int s = 0; s < NST; s++) begin
      logic [11:0] eff;
      logic [3:0]  v;
      eff = (k == 3) ? (st_addr[s] & ~(12'd1 << l)) : st_addr[s];
      if (st_kind[s] == 0) begin
        pm[int'(eff)] = st_data[s];
      end else begin
        v = pm.exists(int'(eff)) ? pm[int'(eff)] : 4'h0;
        if (k == 1 && eff == a) v = v ^ m;
        if (st_kind[s] == 2 && k != 2) v = 4'hF;
        if (ps < 0 && (((v ^ st_data[s]) & st_mask[s]) != 4'h0)) begin
          ps = s; pa = st_addr[s]; pe = st_data[s]; pg = v;
        end
      end
    end
  endfunction

  // ---------------- one full run
  task automatic run_one(input int k, input logic [11:0] a, input logic [3:0] m, input int l,
                         input int mid, input int want, input string wreq);
    int ps; logic [11:0] pa; logic [3:0] pe, pg;
    int n, ea, ec, ed, eb;
    bit seen;
    fk = k; fa = a; fm = m; fl = l;
    clear_ram();
    predict(k, a, m, l, ps, pa, pe, pg);
    n = 0; ea = 0; ec = 0; ed = 0; eb = 0; seen = 0;
    @(negedge clk);
    start = 1'b1;
    while (!seen && n < RUNLEN + 20) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = (mid > 0 && n == mid);
      if (done) begin
        seen = 1;
      end else if (n <= RUNLEN) begin
        int p, s, ph;
        logic ecs, ewe, eoe;
        p = (n - 1) / CYC; s = p / 3; ph = p % 3;
        ecs = 1'b1; ewe = 1'b1; eoe = 1'b0;
        if (ph == 1 && st_kind[s] == 0) begin ecs = 1'b0; ewe = 1'b0; eoe = 1'b1; end
        if (ph == 1 && st_kind[s] == 1) ecs = 1'b0;
        if (mem_addr != st_addr[s]) ea++;
        if (mem_cs_n != ecs || mem_we_n != ewe || mem_dq_oe != eoe) ec++;
        if (eoe && mem_dq_out != st_data[s]) ed++;
        if (!busy) eb++;
      end
    end
    start = 1'b0;
    chk(n == RUNLEN + 1, "R9", "clocks from start to done", n, RUNLEN + 1);
    if (mid > 0) chk(n == RUNLEN + 1, "R10", "run length with start while busy", n, RUNLEN + 1);
    chk(ea == 0, "R3", "address errors", ea, 0);
    chk(ec == 0, "R2", "enable/phase errors", ec, 0);
    chk(ed == 0, "R5", "write data errors", ed, 0);
    chk(eb == 0, "R4", "busy low inside run", eb, 0);
    chk(pass == (ps < 0), "R9", "pass flag", pass, ps < 0);
    if (ps >= 0)
      chk({fail_step, fail_addr, fail_exp, fail_got} == {8'(ps), pa, pe, pg}, "R9",
          "first failure record", {fail_step, fail_addr, fail_exp, fail_got}, {8'(ps), pa, pe, pg});
    if (want == -1) chk(pass == 1'b1, wreq, "clean part verdict", pass, 1);
    if (want >= 0)  chk(!pass && int'(fail_step) == want, wreq, "first failing step", fail_step, want);
    @(negedge clk);
    chk(!done, "R9", "done width", done, 0);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    build_script();
    clear_ram();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle state under reset
    chk(!busy && !done && !pass && mem_cs_n && mem_we_n && !mem_dq_oe, "R1", "reset state",
        {busy, done, pass, mem_cs_n, mem_we_n, mem_dq_oe}, 6'b000110);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    run_one(0, 12'h000, 4'h0, 0, 0, -1, "R6");       // fault-free part, strobe window
    run_one(1, 12'h000, 4'h4, 0, 0, 9, "R7");        // bit 2 flipped at address 0
    run_one(2, 12'h000, 4'h0, 0, 0, 69, "R8");       // chip select ignored
    run_one(1, 12'hFFF, 4'h1, 0, 0, 41, "R5");       // bit 0 flipped at top entry
    run_one(3, 12'h000, 4'h0, 11, 0, 40, "R3");      // address line 11 stuck low
    run_one(0, 12'h000, 4'h0, 0, 777, -1, "R10");    // start pulsed mid-run

    // R11: reset part way through a run
    fk = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && mem_cs_n && mem_we_n && !mem_dq_oe, "R11", "idle after mid-run reset",
        {busy, done, mem_cs_n, mem_we_n, mem_dq_oe}, 5'b00110);
    rst = 1'b0;
    @(negedge clk);
    run_one(0, 12'h000, 4'h0, 0, 0, -1, "R11");

    for (int r = 0; r < 6; r++) begin
      int k, l;
      logic [11:0] a;
      logic [3:0]  m;
      k = $urandom_range(0, 3);
      a = 12'hFFF >> (12 - $urandom_range(0, 12));
      m = 4'($urandom_range(1, 15));
      l = $urandom_range(0, 11);
      run_one(k, a, m, l, 0, -2, "R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule